// File: doc/BRIEF.md
# Pin-Change Interrupt Controller

This block watches twelve general-purpose inputs, split into a low bank of eight pins (indices 0 to 7) and a high bank of four pins (indices 8 to 11), plus one dedicated external interrupt line. Every input passes through a two-flop synchroniser. A level change on any pin whose mask bit is set raises the flag of that pin's bank. The external line raises its own flag according to a programmable sense mode. Each flag drives an interrupt request only when its matching enable bit is also set. A combinational wake output reports a pending enabled change without needing a clock.

Software reaches the masks, enables, flags and sense mode through a small register port. A write either replaces a whole byte or sets or clears one addressed bit. Flags are cleared by writing a one to them. A single-bit write to the flag register clears only the addressed flag and leaves any other pending flag alone.

A four-state arming machine blocks change detection until the synchroniser and the previous-sample register hold real pin values. Its states are WARM0, WARM1, WARM2 and LIVE. Reset enters WARM0. The transitions are WARM0 to WARM1, WARM1 to WARM2 and WARM2 to LIVE, one per clock. LIVE then holds until the next reset.

Top module: `pinchg_irq`

## Requirements
- R1: After reset every register reads 0, and irq_ext_o, irq_grp0_o, irq_grp1_o and wake_o are all 0.
- R2: No flag is set during the first three clock edges after reset. Pins held high through reset therefore produce no flag.
- R3: A level change on pin i (0..7) whose bit i is set in the low mask (address 0) sets flag bit 4 of the flag register (address 3). The flag is readable after the third rising edge that follows the input change. A change on an unmasked pin sets nothing.
- R4: A change on pin 8+j with bit j set in the high mask (address 1) sets flag bit 5. Bits 7:4 of the high mask always read 0.
- R5: Flags set whether or not their enable is set. Enable bits live at address 2: bit 4 for the low bank, bit 5 for the high bank, bit 6 for the external line. Each irq output is high exactly when both its flag and its enable are 1.
- R6: A full-byte write to the flag register clears each flag whose data bit is 1 and leaves flags whose data bit is 0 untouched.
- R7: A single-bit write (wr_bit=1) changes only bit wr_bit_idx of the addressed register. On the flag register, a value of 1 clears only the addressed flag and a value of 0 does nothing.
- R8: If a flag-setting change and a clearing write for the same flag take effect on the same edge, the flag stays set.
- R9: The external sense field is bits 1:0 of address 4. Its codes are 00 for low level (the flag sets on every cycle the line is low), 01 for any edge, 10 for falling edge and 11 for rising edge. The external flag is bit 6.
- R10: wake_o is combinational and is high in LIVE under either of two conditions. The first is a raw pin input that differs from its last sampled value while both its mask bit and its bank enable are 1. The second is the external enable set with low-level sense while ext_i is low.
- R11: Register map: 0 low mask, 1 high mask, 2 enables, 3 flags, 4 sense. Unimplemented bits and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 12 | Monitored pins, low bank in bits 7:0 |
| ext_i | input | 1 | Dedicated external interrupt line |
| wr_en | input | 1 | Register write strobe |
| wr_bit | input | 1 | 1 selects a single-bit write, 0 a full-byte write |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Full-byte write data |
| wr_bit_idx | input | 3 | Bit index for a single-bit write |
| wr_bit_val | input | 1 | Value for a single-bit write |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| irq_ext_o | output | 1 | External line interrupt request |
| irq_grp0_o | output | 1 | Low-bank interrupt request |
| irq_grp1_o | output | 1 | High-bank interrupt request |
| wake_o | output | 1 | Asynchronous wake indication |

## Verification
Random pin vectors are applied under random masks and enables. This shows whether each bank's flag follows only the masked changed bits and whether each request combines flag and enable. Directed cases follow. Pins held high through reset separate correct arming from false detection at start-up. Each sense code is driven with both falling and rising edges, so any edge swap between modes is caught. A change timed to land on the same edge as its clear separates set priority from clear priority. Single-bit writes are aimed at one flag while the other stays pending, which shows whether the write disturbs neighbouring bits.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] ADDR_MASK0 = 3'd0;
    localparam logic [AW-1:0] ADDR_MASK1 = 3'd1;
    localparam logic [AW-1:0] ADDR_EN    = 3'd2;
    localparam logic [AW-1:0] ADDR_FLAG  = 3'd3;
    localparam logic [AW-1:0] ADDR_SENSE = 3'd4;

    // bit positions shared by the enable and flag registers
    localparam int POS_G0  = 4;
    localparam int POS_G1  = 5;
    localparam int POS_EXT = 6;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_t;

    typedef enum logic [1:0] {
        WARM0 = 2'd0,
        WARM1 = 2'd1,
        WARM2 = 2'd2,
        LIVE  = 2'd3
    } arm_t;

    function automatic logic [DW-1:0] put_bit(input logic [DW-1:0] v,
                                              input logic [AW-1:0] idx,
                                              input logic b);
        logic [DW-1:0] r;
        r = v;
        r[idx] = b;
        return r;
    endfunction
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
    parameter int W      = 13,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pinchg_arm.sv
module pinchg_arm
    import pinchg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic live
);
    arm_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WARM0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WARM0: state_d = WARM1;
            WARM1: state_d = WARM2;
            WARM2: state_d = LIVE;
            LIVE:  state_d = LIVE;
        endcase
    end

    always_comb begin
        live = (state_q == LIVE);
    end

    // once armed, detection stays armed until reset (R2)
    assert_live_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> live);
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq
    import pinchg_pkg::*;
#(
    parameter int N0 = 8,
    parameter int N1 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N0+N1-1:0]  pin_i,
    input  logic              ext_i,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        wr_bit_idx,
    input  logic              wr_bit_val,
    input  logic [2:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              irq_ext_o,
    output logic              irq_grp0_o,
    output logic              irq_grp1_o,
    output logic              wake_o
);
    localparam int NP = N0 + N1;
    localparam int SW = NP + 1;
    localparam logic [DW-1:0] KEEP0 = DW'((1 << N0) - 1);
    localparam logic [DW-1:0] KEEP1 = DW'((1 << N1) - 1);
    localparam logic [DW-1:0] KEEPE = DW'((1 << POS_G0) | (1 << POS_G1) | (1 << POS_EXT));
    localparam logic [DW-1:0] KEEPS = DW'(3);

    logic          live;
    logic [SW-1:0] s_q, prev_q, chg;
    logic [DW-1:0] mask0_q, mask1_q, en_q, sense_q;
    logic [DW-1:0] mask0_d, mask1_d, en_d, sense_d;
    logic [2:0]    flag_q, flag_clr, flag_set;   // {ext, g1, g0}
    logic          ext_evt;
    sense_t        sense;

    pinchg_sync #(.W(SW), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ext_i, pin_i}), .q(s_q)
    );

    pinchg_arm u_arm (.clk(clk), .rst_n(rst_n), .live(live));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= s_q;
    end

    assign chg   = s_q ^ prev_q;
    assign sense = sense_t'(sense_q[1:0]);

    always_comb begin
        ext_evt = 1'b0;
        unique case (sense)
            SNS_LOW:  ext_evt = ~s_q[NP];
            SNS_ANY:  ext_evt = chg[NP];
            SNS_FALL: ext_evt = prev_q[NP] & ~s_q[NP];
            SNS_RISE: ext_evt = ~prev_q[NP] & s_q[NP];
        endcase
    end

    assign flag_set[0] = live & |(chg[N0-1:0] & mask0_q[N0-1:0]);
    assign flag_set[1] = live & |(chg[NP-1:N0] & mask1_q[N1-1:0]);
    assign flag_set[2] = live & ext_evt;

    // register writes: full byte or single addressed bit
    function automatic logic [DW-1:0] next_img(input logic [DW-1:0] cur,
                                               input logic [AW-1:0] a,
                                               input logic [DW-1:0] keep);
        logic [DW-1:0] r;
        r = cur;
        if (wr_en && wr_addr == a)
            r = wr_bit ? put_bit(cur, wr_bit_idx, wr_bit_val) : wr_data;
        return r & keep;
    endfunction

    always_comb begin
        mask0_d = next_img(mask0_q, ADDR_MASK0, KEEP0);
        mask1_d = next_img(mask1_q, ADDR_MASK1, KEEP1);
        en_d    = next_img(en_q,    ADDR_EN,    KEEPE);
        sense_d = next_img(sense_q, ADDR_SENSE, KEEPS);
    end

    always_comb begin
        flag_clr = 3'b000;
        if (wr_en && wr_addr == ADDR_FLAG) begin
            if (!wr_bit)
                flag_clr = {wr_data[POS_EXT], wr_data[POS_G1], wr_data[POS_G0]};
            else if (wr_bit_val)
                flag_clr = {wr_bit_idx == 3'(POS_EXT), wr_bit_idx == 3'(POS_G1),
                            wr_bit_idx == 3'(POS_G0)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask0_q <= '0;
            mask1_q <= '0;
            en_q    <= '0;
            sense_q <= '0;
            flag_q  <= '0;
        end else begin
            mask0_q <= mask0_d;
            mask1_q <= mask1_d;
            en_q    <= en_d;
            sense_q <= sense_d;
            flag_q  <= (flag_q & ~flag_clr) | flag_set;   // set wins (R8)
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_MASK0: rd_data = mask0_q;
            ADDR_MASK1: rd_data = mask1_q;
            ADDR_EN:    rd_data = en_q;
            ADDR_FLAG:  begin
                rd_data[POS_G0]  = flag_q[0];
                rd_data[POS_G1]  = flag_q[1];
                rd_data[POS_EXT] = flag_q[2];
            end
            ADDR_SENSE: rd_data = sense_q;
            default:    rd_data = '0;
        endcase
    end

    assign irq_grp0_o = flag_q[0] & en_q[POS_G0];
    assign irq_grp1_o = flag_q[1] & en_q[POS_G1];
    assign irq_ext_o  = flag_q[2] & en_q[POS_EXT];

    assign wake_o = live & (
          |((pin_i[N0-1:0] ^ prev_q[N0-1:0]) & mask0_q[N0-1:0] & {N0{en_q[POS_G0]}})
        | |((pin_i[NP-1:N0] ^ prev_q[NP-1:N0]) & mask1_q[N1-1:0] & {N1{en_q[POS_G1]}})
        | (en_q[POS_EXT] & (sense == SNS_LOW) & ~ext_i));

    // no flag may rise before the arming machine reaches LIVE
    assert_no_early_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> ((flag_q & ~$past(flag_q)) == 3'b000));

    // an unmasked or absent change never raises the low-bank flag
    assert_mask_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[0] && ((chg[N0-1:0] & mask0_q[N0-1:0]) == '0)) |=> !flag_q[0]);

    // a full-byte one clears the low-bank flag when no change coincides
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit && wr_addr == ADDR_FLAG && wr_data[POS_G0] && !flag_set[0])
        |=> !flag_q[0]);

    // a single-bit write to the low mask leaves every other bit alone
    assert_bit_write_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit && wr_addr == ADDR_MASK0)
        |=> (((mask0_q ^ $past(mask0_q)) & ~(8'd1 << $past(wr_bit_idx))) == 8'd0));

    // a detected change always leaves its flag set, even against a clear
    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[1] |=> flag_q[1]);
endmodule

// File: tb/test_pinchg_irq.sv
module test_pinchg_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pin_i = 12'hFFF;
    logic        ext_i = 1'b1;
    logic        wr_en = 1'b0, wr_bit = 1'b0, wr_bit_val = 1'b0;
    logic [2:0]  wr_addr = 3'd0, wr_bit_idx = 3'd0, rd_addr = 3'd0;
    logic [7:0]  wr_data = 8'd0, rd_data;
    logic        irq_ext_o, irq_grp0_o, irq_grp1_o, wake_o;

    int total = 0;
    int bad = 0;

    pinchg_irq i_pinchg_irq (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .ext_i(ext_i),
        .wr_en(wr_en), .wr_bit(wr_bit), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_ext_o(irq_ext_o), .irq_grp0_o(irq_grp0_o),
        .irq_grp1_o(irq_grp1_o), .wake_o(wake_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_bit = 1'b0; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wrb(input logic [2:0] a, input logic [2:0] idx, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_bit = 1'b1; wr_addr = a; wr_bit_idx = idx; wr_bit_val = v;
        @(negedge clk);
        wr_en = 1'b0; wr_bit = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // expected flag image (bit 4 low bank, bit 5 high bank) for one pin update
    function automatic logic [7:0] exp_flags(input logic [11:0] o, input logic [11:0] n,
                                             input logic [7:0] m0, input logic [3:0] m1);
        logic [11:0] d;
        d = o ^ n;
        return {2'b00, |(d[11:8] & m1), |(d[7:0] & m0), 4'b0000};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset register", d, 8'h00);
        end
        check("R1 reset outputs", {irq_ext_o, irq_grp0_o, irq_grp1_o, wake_o}, 4'b0000);
        rst_n = 1'b1;
        settle();
        // R2: pins high through reset give no flag
        rd(3'd3, d);
        check("R2 no flag after arming", d, 8'h00);

        // R11: map and unused bits
        wr(3'd1, 8'hFF); rd(3'd1, d); check("R4 high mask upper bits zero", d, 8'h0F);
        wr(3'd2, 8'hFF); rd(3'd2, d); check("R11 enable bits", d, 8'h70);
        wr(3'd4, 8'hFF); rd(3'd4, d); check("R11 sense bits", d, 8'h03);
        rd(3'd6, d);      check("R11 unused address", d, 8'h00);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd4, 8'h03);

        // R3: masked and unmasked low-bank changes, exact timing
        wr(3'd0, 8'h01);
        @(negedge clk); pin_i[1] = 1'b0;
        settle(); rd(3'd3, d); check("R3 unmasked change", d, 8'h00);
        @(negedge clk); pin_i[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(3'd3, d); check("R3 flag not before third edge", d, 8'h00);
        @(negedge clk);
        rd(3'd3, d); check("R3 flag after third edge", d, 8'h10);

        // R5: flag without enable gives no irq, enable then asserts it
        check("R5 irq off while disabled", irq_grp0_o, 1'b0);
        wr(3'd2, 8'h10); #1;
        check("R5 irq when flag and enable", irq_grp0_o, 1'b1);

        // R8: change and clear on the same edge keep the flag
        @(negedge clk); pin_i[0] = 1'b1;
        @(negedge clk);
        wr(3'd3, 8'h10);
        rd(3'd3, d); check("R8 set beats clear", d, 8'h10);
        // R6: a zero bit does not clear, a one bit does
        wr(3'd3, 8'h20); rd(3'd3, d); check("R6 write zero keeps flag", d, 8'h10);
        wr(3'd3, 8'h10); rd(3'd3, d); check("R6 write one clears", d, 8'h00);

        // R4: high bank
        wr(3'd1, 8'h04);
        @(negedge clk); pin_i[10] = 1'b0;
        settle(); rd(3'd3, d); check("R4 high bank flag", d, 8'h20);
        check("R5 high irq off while disabled", irq_grp1_o, 1'b0);

        // R7: single-bit operations
        @(negedge clk); pin_i[0] = 1'b0;
        settle(); rd(3'd3, d); check("R7 two flags pending", d, 8'h30);
        wrb(3'd3, 3'd5, 1'b1); rd(3'd3, d); check("R7 clear one flag only", d, 8'h10);
        wrb(3'd3, 3'd4, 1'b0); rd(3'd3, d); check("R7 zero bit write no effect", d, 8'h10);
        wr(3'd0, 8'hA5);
        wrb(3'd0, 3'd1, 1'b1); rd(3'd0, d); check("R7 bit set mask", d, 8'hA7);
        wrb(3'd0, 3'd7, 1'b0); rd(3'd0, d); check("R7 bit clear mask", d, 8'h27);
        wr(3'd3, 8'h70);

        // R10: wake
        wr(3'd0, 8'h04); wr(3'd2, 8'h10);
        @(negedge clk); pin_i[3] = ~pin_i[3]; #1;
        check("R10 unmasked pin no wake", wake_o, 1'b0);
        settle();
        @(negedge clk); pin_i[2] = ~pin_i[2]; #1;
        check("R10 wake without clock edge", wake_o, 1'b1);
        settle();
        check("R10 wake drops once sampled", wake_o, 1'b0);
        wr(3'd3, 8'h70);

        // R9: external sense modes (ext_i currently 1)
        wr(3'd2, 8'h40);
        wr(3'd4, 8'h02);
        @(negedge clk); ext_i = 1'b0; settle();
        rd(3'd3, d); check("R9 falling edge sets", d, 8'h40);
        check("R9 ext irq", irq_ext_o, 1'b1);
        wr(3'd3, 8'h40);
        @(negedge clk); ext_i = 1'b1; settle();
        rd(3'd3, d); check("R9 rising ignored in falling mode", d, 8'h00);
        wr(3'd4, 8'h03);
        @(negedge clk); ext_i = 1'b0; settle();
        rd(3'd3, d); check("R9 falling ignored in rising mode", d, 8'h00);
        @(negedge clk); ext_i = 1'b1; settle();
        rd(3'd3, d); check("R9 rising edge sets", d, 8'h40);
        wr(3'd3, 8'h40);
        wr(3'd4, 8'h01);
        @(negedge clk); ext_i = 1'b0; settle();
        rd(3'd3, d); check("R9 any edge falling", d, 8'h40);
        wr(3'd3, 8'h40);
        @(negedge clk); ext_i = 1'b1; settle();
        rd(3'd3, d); check("R9 any edge rising", d, 8'h40);
        wr(3'd3, 8'h40);
        wr(3'd4, 8'h00);
        @(negedge clk); ext_i = 1'b0; #1;
        check("R10 level wake", wake_o, 1'b1);
        settle();
        wr(3'd3, 8'h40);
        rd(3'd3, d); check("R9 low level reasserts", d, 8'h40);
        @(negedge clk); ext_i = 1'b1; settle();
        wr(3'd3, 8'h40);
        rd(3'd3, d); check("R9 level clears when high", d, 8'h00);
        wr(3'd4, 8'h03);

        // random patterns for R3, R4, R5
        for (int it = 0; it < 60; it++) begin
            logic [7:0]  m0, en;
            logic [3:0]  m1;
            logic [11:0] np, op;
            logic [7:0]  e;
            m0 = 8'($urandom);
            m1 = 4'($urandom);
            en = {2'b00, 2'($urandom), 4'b0000};
            np = 12'($urandom);
            wr(3'd0, m0); wr(3'd1, {4'h0, m1}); wr(3'd2, en);
            wr(3'd3, 8'h70);
            op = pin_i;
            @(negedge clk); pin_i = np;
            settle();
            e = exp_flags(op, np, m0, m1);
            rd(3'd3, d);
            check("R3 R4 random bank flags", d & 8'h30, e);
            check("R5 random irq", {irq_grp1_o, irq_grp0_o}, {e[5] & en[5], e[4] & en[4]});
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule